// File: doc/BRIEF.md
# Three-Voice State-Variable Filter Mixer

This block combines three signed voice samples into one mono sample. Each voice is first scaled down by an arithmetic right shift. A per-voice routing bit then sends it either into a two-integrator state-variable filter or into a bypass sum. The highpass, bandpass and lowpass outputs of the filter can each be added to the bypass sum without weighting. A fixed DC offset is added, and the total is multiplied by a 4-bit volume.

The filter state advances once per clock. The cutoff-to-coefficient mapping is done outside the block. The block exports its 11-bit cutoff register so that a neighbour can compute the `w0_coef` input from it. The block derives the inverse-Q factor from the resonance nibble itself.

Configuration is written one byte at a time through a 2-bit address. A filter-enable input bypasses the filter completely and clears its state.

Top module: `svf_mixer`

## Requirements
- R1: After reset every configuration field, every filter state and the bypass sum are zero, so `mix_out` is 0 and `cutoff_o` is 0.
- R2: A write with `cfg_addr`=0 loads cutoff bits 2:0 from data bits 2:0. Address 1 loads cutoff bits 10:3 from data bits 7:0. Address 2 loads resonance from data bits 7:4 and the routing bits from data bits 3:0. Address 3 loads voice-3-mute from bit 7, the mode bits from bits 6:4 (bit 6 highpass, bit 5 bandpass, bit 4 lowpass) and the volume from bits 3:0. A written field is visible after the write edge.
- R3: Each voice is arithmetically shifted right by 7 before any summation, so negative inputs round toward minus infinity.
- R4: Routing bit 0 sends voice 1 into the filter, bit 1 sends voice 2 and bit 2 sends voice 3. Every unrouted voice goes to the bypass sum. Routing bit 3 has no effect.
- R5: When voice-3-mute is set and routing bit 2 is clear, voice 3 contributes nothing. When routing bit 2 is set, voice 3 is not muted, and this also holds while the filter is disabled.
- R6: On each enabled clock the block first sets bandpass to bandpass − (w0dt·highpass)>>14. It then sets lowpass to lowpass − (w0dt·new bandpass)>>14. Finally it sets highpass to (new bandpass·invQ)>>10 − new lowpass − filter input. All arithmetic is 32-bit signed.
- R7: invQ is 1024/(0.707 + res/15), truncated, for res 0 to 15 (1448 at 0, 599 at 15).
- R8: `mix_out` = (bypass sum + the enabled filter outputs + (−454)) × volume. The filter outputs are added unweighted.
- R9: With volume 0, `mix_out` is 0.
- R10: While `filt_en` is low, the bypass sum is the sum of all three voices after the mute rule, and all three filter states are cleared to 0.
- R11: w0dt is `w0_coef` shifted right by 6. With `w0_coef` below 64, bandpass and lowpass hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 2 | Configuration byte select |
| cfg_wdata | input | 8 | Configuration byte |
| filt_en | input | 1 | Filter enable; low bypasses and clears the filter |
| w0_coef | input | W0_W | Precomputed cutoff coefficient |
| voice1_in | input | VOICE_W | Voice 1 sample, signed |
| voice2_in | input | VOICE_W | Voice 2 sample, signed |
| voice3_in | input | VOICE_W | Voice 3 sample, signed |
| cutoff_o | output | 11 | Current cutoff register for the coefficient mapper |
| mix_out | output | 32 | Mixed, scaled output sample, signed |

## Verification
Bypass-only tests with hand-computed values separate the scaling shift, the DC offset and the volume. They include a negative input of −1, which distinguishes an arithmetic shift from a logical one or from truncating division. With `w0_coef` held at 0, the highpass equals the negated filter input. This makes the routing and the mute rule directly visible: a wrongly muted, misrouted or routing-bit-3-sensitive voice shifts the output by a known amount. A square-wave drive at a real cutoff, run at both resonance extremes and then through all eight mode settings, is compared every cycle with an independent model. That comparison separates the ordering of the integrator steps, the inverse-Q values and the mode-bit positions. Toggling the filter enable mid-run checks that the state clears and that filtering restarts from zero.

// File: rtl/svf_pkg.sv
package svf_pkg;
  localparam int ACC_W = 32;
  typedef logic signed [ACC_W-1:0] acc_t;

  typedef struct packed {
    logic [10:0] cutoff;
    logic [3:0]  res;
    logic [3:0]  route;
    logic        v3_mute;
    logic [2:0]  mode;   // [2]=highpass [1]=bandpass [0]=lowpass
    logic [3:0]  vol;
  } svf_cfg_t;

  // 1024/(0.707+r/15) rewritten as an integer ratio
  function automatic acc_t inv_q(input logic [3:0] r);
    int unsigned den;
    den = 32'd10605 + 32'd1000 * {28'd0, r};
    return acc_t'(32'd15360000 / den);
  endfunction

  // (a*b) >>> sh in 64-bit, truncated back to accumulator width
  function automatic acc_t mul_shr(input acc_t a, input acc_t b, input int sh);
    longint p;
    p = longint'(a) * longint'(b);
    return acc_t'(p >>> sh);
  endfunction
endpackage

// File: rtl/svf_regs.sv
module svf_regs
  import svf_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [1:0]     addr,
  input  logic [7:0]     wdata,
  output svf_cfg_t       cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      case (addr)
        2'd0: cfg.cutoff[2:0]  <= wdata[2:0];
        2'd1: cfg.cutoff[10:3] <= wdata;
        2'd2: begin
          cfg.res   <= wdata[7:4];
          cfg.route <= wdata[3:0];
        end
        default: begin
          cfg.v3_mute <= wdata[7];
          cfg.mode    <= wdata[6:4];
          cfg.vol     <= wdata[3:0];
        end
      endcase
    end
  end

  a_r2_vol_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd3) |=> (cfg.vol == $past(wdata[3:0])));
  a_r2_cutoff_high: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd1) |=> (cfg.cutoff[10:3] == $past(wdata)));
endmodule

// File: rtl/svf_route.sv
module svf_route
  import svf_pkg::*;
#(
  parameter int VOICE_W = 20,
  parameter int SHIFT   = 7
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [VOICE_W-1:0]  v1,
  input  logic signed [VOICE_W-1:0]  v2,
  input  logic signed [VOICE_W-1:0]  v3,
  input  logic [3:0]                 route,
  input  logic                       v3_mute,
  input  logic                       filt_en,
  output acc_t                       vi,
  output acc_t                       vnf
);
  localparam int NV = 3;

  logic signed [VOICE_W-1:0] vin [NV];
  acc_t scaled [NV];
  acc_t eff    [NV];
  logic kill_v3;

  assign vin[0] = v1;
  assign vin[1] = v2;
  assign vin[2] = v3;
  assign kill_v3 = v3_mute && !route[2];

  for (genvar g = 0; g < NV; g++) begin : g_scale
    logic signed [VOICE_W-1:0] shv;
    assign shv       = vin[g] >>> SHIFT;
    assign scaled[g] = acc_t'(shv);
    if (g == NV - 1) begin : g_mute
      assign eff[g] = kill_v3 ? '0 : scaled[g];
    end else begin : g_pass
      assign eff[g] = scaled[g];
    end
  end

  always_comb begin
    vi  = '0;
    vnf = '0;
    for (int i = 0; i < NV; i++) begin
      if (filt_en && route[i]) vi  = vi + eff[i];
      else                     vnf = vnf + eff[i];
    end
  end

  a_r10_no_filter_input: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_en |-> (vi == '0));
  a_r5_muted_voice_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (v3_mute && !route[2]) |-> (vi + vnf == scaled[0] + scaled[1]));
endmodule

// File: rtl/svf_core.sv
module svf_core
  import svf_pkg::*;
#(
  parameter int W0_W   = 18,
  parameter int DT_SH  = 6,
  parameter int INT_SH = 14,
  parameter int Q_SH   = 10
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             filt_en,
  input  logic [W0_W-1:0]  w0,
  input  acc_t             invq,
  input  acc_t             vi,
  output acc_t             hp,
  output acc_t             bp,
  output acc_t             lp
);
  localparam int DT_W = W0_W - DT_SH;

  logic [DT_W-1:0] w0dt_u;
  acc_t w0dt;
  acc_t bp_n, lp_n, hp_n;

  assign w0dt_u = DT_W'(w0 >> DT_SH);
  assign w0dt   = acc_t'({1'b0, w0dt_u});

  always_comb begin
    bp_n = bp - mul_shr(w0dt, hp, INT_SH);
    lp_n = lp - mul_shr(w0dt, bp_n, INT_SH);
    hp_n = mul_shr(bp_n, invq, Q_SH) - lp_n - vi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !filt_en) begin
      hp <= '0;
      bp <= '0;
      lp <= '0;
    end else begin
      hp <= hp_n;
      bp <= bp_n;
      lp <= lp_n;
    end
  end

  a_r10_state_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_en |=> (hp == '0 && bp == '0 && lp == '0));
  a_r11_frozen_integrators: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && w0dt == '0) |=> ($stable(bp) && $stable(lp)));
endmodule

// File: rtl/svf_mix.sv
module svf_mix
  import svf_pkg::*;
#(
  parameter int DC_OFFSET = -454
)(
  input  logic        clk,
  input  logic        rst_n,
  input  acc_t        vnf,
  input  acc_t        hp,
  input  acc_t        bp,
  input  acc_t        lp,
  input  logic [2:0]  mode,
  input  logic [3:0]  vol,
  output acc_t        mix
);
  acc_t sum;

  always_comb begin
    sum = vnf + acc_t'(DC_OFFSET);
    if (mode[2]) sum = sum + hp;
    if (mode[1]) sum = sum + bp;
    if (mode[0]) sum = sum + lp;
    mix = mul_shr(sum, acc_t'({28'd0, vol}), 0);
  end

  a_r9_silent_at_zero_volume: assert property (@(posedge clk) disable iff (!rst_n)
    (vol == 4'd0) |-> (mix == '0));
endmodule

// File: rtl/svf_mixer.sv
module svf_mixer
  import svf_pkg::*;
#(
  parameter int VOICE_W     = 20,
  parameter int W0_W        = 18,
  parameter int VOICE_SHIFT = 7,
  parameter int DC_OFFSET   = -454
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_addr,
  input  logic [7:0]                 cfg_wdata,
  input  logic                       filt_en,
  input  logic [W0_W-1:0]            w0_coef,
  input  logic signed [VOICE_W-1:0]  voice1_in,
  input  logic signed [VOICE_W-1:0]  voice2_in,
  input  logic signed [VOICE_W-1:0]  voice3_in,
  output logic [10:0]                cutoff_o,
  output logic signed [31:0]         mix_out
);
  svf_cfg_t cfg;
  acc_t vi, vnf, vnf_q, hp, bp, lp, invq, mix;

  svf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .cfg(cfg)
  );

  svf_route #(.VOICE_W(VOICE_W), .SHIFT(VOICE_SHIFT)) u_route (
    .clk(clk), .rst_n(rst_n), .v1(voice1_in), .v2(voice2_in), .v3(voice3_in),
    .route(cfg.route), .v3_mute(cfg.v3_mute), .filt_en(filt_en),
    .vi(vi), .vnf(vnf)
  );

  assign invq = inv_q(cfg.res);

  svf_core #(.W0_W(W0_W)) u_core (
    .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .w0(w0_coef),
    .invq(invq), .vi(vi), .hp(hp), .bp(bp), .lp(lp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) vnf_q <= '0;
    else        vnf_q <= vnf;
  end

  svf_mix #(.DC_OFFSET(DC_OFFSET)) u_mix (
    .clk(clk), .rst_n(rst_n), .vnf(vnf_q), .hp(hp), .bp(bp), .lp(lp),
    .mode(cfg.mode), .vol(cfg.vol), .mix(mix)
  );

  assign cutoff_o = cfg.cutoff;
  assign mix_out  = mix;

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (mix_out == 32'sd0 && cutoff_o == 11'd0));
endmodule

// File: tb/svf_mixer_tb.sv
module svf_mixer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic filt_en = 1'b0;
  logic [17:0] w0_coef = '0;
  logic signed [19:0] v1 = '0, v2 = '0, v3 = '0;
  logic [10:0] cutoff_o;
  logic signed [31:0] mix_out;

  int checks = 0;
  int errors = 0;

  // independent model state
  longint m_hp = 0, m_bp = 0, m_lp = 0, m_vnf = 0;
  int m_cut = 0, m_res = 0, m_route = 0, m_mute = 0, m_mode = 0, m_vol = 0;

  always #5ns clk = ~clk;

  svf_mixer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .filt_en(filt_en), .w0_coef(w0_coef),
    .voice1_in(v1), .voice2_in(v2), .voice3_in(v3),
    .cutoff_o(cutoff_o), .mix_out(mix_out)
  );

  function automatic longint floor_div(longint x, longint d);
    longint q = x / d;
    if ((x % d) != 0 && x < 0) q = q - 1;
    return q;
  endfunction

  function automatic longint w32(longint x);
    int t = int'(x);
    return longint'(t);
  endfunction

  function automatic longint m_out();
    longint s = m_vnf - 454;
    if (m_mode[2]) s += m_hp;
    if (m_mode[1]) s += m_bp;
    if (m_mode[0]) s += m_lp;
    return w32(s * m_vol);
  endfunction

  task automatic tick();
    longint s [3];
    longint vi = 0, vnf = 0, w, q, nb, nl, nh;
    int nc = m_cut, nr = m_res, nro = m_route, nm = m_mute, nmo = m_mode, nv = m_vol;
    s[0] = floor_div(longint'(v1), 128);
    s[1] = floor_div(longint'(v2), 128);
    s[2] = floor_div(longint'(v3), 128);
    if (m_mute != 0 && m_route[2] == 1'b0) s[2] = 0;
    for (int i = 0; i < 3; i++)
      if (filt_en && m_route[i]) vi += s[i]; else vnf += s[i];
    w  = longint'(w0_coef) / 64;
    q  = 15360000 / (10605 + 1000 * m_res);
    nb = w32(m_bp - w32(floor_div(w * m_hp, 16384)));
    nl = w32(m_lp - w32(floor_div(w * nb, 16384)));
    nh = w32(w32(floor_div(nb * q, 1024)) - nl - vi);
    if (cfg_we) begin
      case (cfg_addr)
        2'd0: nc = (m_cut & 'h7F8) | int'(cfg_wdata[2:0]);
        2'd1: nc = (m_cut & 'h007) | (int'(cfg_wdata) << 3);
        2'd2: begin nr = int'(cfg_wdata[7:4]); nro = int'(cfg_wdata[3:0]); end
        default: begin nm = int'(cfg_wdata[7]); nmo = int'(cfg_wdata[6:4]); nv = int'(cfg_wdata[3:0]); end
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    if (!filt_en) begin m_hp = 0; m_bp = 0; m_lp = 0; end
    else begin m_hp = nh; m_bp = nb; m_lp = nl; end
    m_vnf = vnf;
    m_cut = nc; m_res = nr; m_route = nro; m_mute = nm; m_mode = nmo; m_vol = nv;
  endtask

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mix after reset", longint'(mix_out), 0);
    chk("R1 cutoff after reset", longint'(cutoff_o), 0);
  endtask

  task automatic t_cutoff();
    wr(2'd0, 8'hFD);
    wr(2'd1, 8'hA3);
    chk("R2 cutoff assembly", longint'(cutoff_o), 'h51D);
    wr(2'd0, 8'h02);
    chk("R2 cutoff low keeps high", longint'(cutoff_o), 'h51A);
  endtask

  task automatic t_scale();
    filt_en = 1'b0;
    wr(2'd3, 8'h01);
    v1 = 20'sd1280; v2 = -20'sd256; v3 = 20'sd640;
    tick();
    chk("R3 bypass sum scaled", longint'(mix_out), -441);
    v1 = -20'sd1; v2 = '0; v3 = '0;
    tick();
    chk("R3 arithmetic shift of -1", longint'(mix_out), -455);
    v1 = 20'sh7FFFF;
    tick();
    chk("R3 max positive", longint'(mix_out), 3641);
  endtask

  task automatic t_volume();
    v1 = 20'sd1280;
    wr(2'd3, 8'h0F);
    tick();
    chk("R9 volume 15", longint'(mix_out), -6660);
    chk("R8 model vol 15", longint'(mix_out), m_out());
    wr(2'd3, 8'h00);
    chk("R9 volume 0 silent", longint'(mix_out), 0);
  endtask

  task automatic t_mute();
    filt_en = 1'b0;
    v1 = '0; v2 = '0; v3 = 20'sd640;
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h81);
    tick();
    chk("R5 voice3 muted when unrouted", longint'(mix_out), -454);
    wr(2'd2, 8'h04);
    tick();
    chk("R5 routed voice3 not muted while disabled", longint'(mix_out), -449);
    filt_en = 1'b1; w0_coef = '0;
    wr(2'd3, 8'hC1);
    tick();
    chk("R5 routed voice3 reaches filter", longint'(mix_out), -459);
  endtask

  task automatic t_route();
    filt_en = 1'b1; w0_coef = '0;
    v1 = 20'sd1280; v2 = '0; v3 = '0;
    wr(2'd3, 8'h41);
    wr(2'd2, 8'h00);
    tick();
    chk("R4 no routing", longint'(mix_out), -444);
    wr(2'd2, 8'h08);
    tick();
    chk("R4 routing bit 3 ignored", longint'(mix_out), -444);
    wr(2'd2, 8'h01);
    tick();
    chk("R4 voice1 to filter", longint'(mix_out), -464);
    v2 = -20'sd256;
    wr(2'd2, 8'h02);
    tick();
    chk("R4 voice2 to filter", longint'(mix_out), -442);
    w0_coef = 18'd63;
    tick();
    chk("R11 sub-64 coefficient keeps integrators", longint'(mix_out), m_out());
  endtask

  task automatic t_dynamics(logic [3:0] res);
    filt_en = 1'b1; w0_coef = 18'd6588;
    wr(2'd2, {res, 4'h7});
    wr(2'd3, 8'h7F);
    for (int n = 0; n < 200; n++) begin
      v1 = ((n / 20) % 2 == 0) ? 20'sd262144 : -20'sd262144;
      v2 = 20'sd4000; v3 = -20'sd9000;
      tick();
      chk(res == 0 ? "R6 R7 step at res 0" : "R6 R7 step at res 15",
          longint'(mix_out), m_out());
    end
  endtask

  task automatic t_modes();
    for (int m = 0; m < 8; m++) begin
      wr(2'd3, 8'(8'h0F | (m << 4)));
      chk("R8 mode selection", longint'(mix_out), m_out());
    end
  endtask

  task automatic t_disable();
    filt_en = 1'b0;
    v1 = 20'sd1280; v2 = -20'sd256; v3 = 20'sd640;
    tick();
    chk("R10 disabled sums all voices", longint'(mix_out), (13 - 454) * 15);
    chk("R10 disabled model", longint'(mix_out), m_out());
    filt_en = 1'b1;
    for (int n = 0; n < 10; n++) begin
      tick();
      chk("R10 restart from cleared state", longint'(mix_out), m_out());
    end
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cutoff();
    t_scale();
    t_volume();
    t_mute();
    t_route();
    t_dynamics(4'd0);
    t_dynamics(4'd15);
    t_modes();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule